// File: doc/BRIEF.md
# Multi-mode 16-bit timer counter

This block is a 16-bit timer peripheral with a small register port (write enable, address, write data and combinational read data). A single counter advances on a count step that comes either from a prescaled tick supplied by the system or from edges on an external event pin. The counter runs in one of four modes: free running, clear on reaching a limit, up-down (phase-correct) counting and frequency generation. In frequency generation the limit is taken from compare channel A.

Three compare channels each own a buffered compare value, a match flag and a waveform output that toggles on every match. The buffered values pass into the active compare registers only at a point in the period that depends on the mode, so a new duty cycle never cuts a period short. One capture channel latches the counter on a chosen edge of the capture pin, optionally through a four-sample majority noise filter. Overflow, the three matches and capture each keep a sticky flag, and each flag raises its own interrupt line when it is enabled. A sleep bit freezes the whole count engine.

Top module: `tmr16_core`

## Requirements
- R1: After reset the counter, all flags, all interrupt lines and all waveform outputs are zero.
- R2: Mode 0 (free run) counts up by one per step. When a step moves the counter from 0xFFFF to 0, the overflow flag (flag bit 0) is set.
- R3: Mode 1 (clear on limit) counts up to the limit register. The step after the counter equals the limit loads zero and sets the overflow flag.
- R4: Mode 2 (up-down) counts up to the limit and then down to zero. The overflow flag is set when the counter reaches zero on the way down. A compare match toggles its waveform output in both directions.
- R5: Mode 3 (frequency) behaves like mode 1, but the limit is the active compare A value.
- R6: When a step makes the counter equal to an active compare value, that channel's flag (bits 1 to 3 for A to C) is set and its waveform output toggles. A direct write to the counter never causes a match. A counter write overrides a step in the same cycle and resets the count direction to up.
- R7: Writes to the compare addresses land in buffers. The buffers are copied to the active compare registers at the update point: the wrap to zero in modes 0, 1 and 3, or the turn at the limit in mode 2. While the clock select is 0 (stopped), the copy happens every cycle.
- R8: Clock select values: 1 is the tick input, 2 is rising edges of the event pin, 3 is falling edges of the event pin. Each qualifying edge gives exactly one step.
- R9: On the selected capture edge (control bit 4: 1 rising, 0 falling), the counter value is stored in the capture register and flag bit 4 is set.
- R10: With the filter enabled (control bit 5), a capture level change is accepted only after four equal consecutive samples. A pulse of three clocks is ignored, and an accepted edge is captured exactly four clocks later than it is without the filter.
- R11: Writing a one to a flag bit clears it, and a flag being set in the same cycle wins over the clear. Interrupt line i is high exactly while flag i and enable bit i are both set.
- R12: While the sleep bit (control bit 6) is set, the counter does not change and no capture is recorded.
- R13: Register addresses are: 0 control, 1 counter, 2 limit, 3 to 5 compare A to C buffers, 6 capture, 7 flags, 8 interrupt enables. Control bits [1:0] hold the mode and bits [3:2] the clock select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for addr |
| tick_i | input | 1 | Prescaled count tick, one step per high cycle |
| evt_i | input | 1 | External event pin (asynchronous) |
| cap_i | input | 1 | Capture pin (asynchronous) |
| wave_o | output | 3 | Compare waveform outputs, A in bit 0 |
| irq_o | output | 5 | Interrupt requests: overflow, compare A to C, capture |

## Verification
Two collisions are provoked on purpose. In the first, a counter write and a count step land in the same cycle. In the second, a compare match sets flag A in the very cycle in which software writes a one to clear it. The bench holds the tick high, writes the counter to one below compare A, and then issues the flag-clear write on the next edge. The flag must read back as set, and only a later clear with no match pending may remove it. The counter-write collision is judged from the value the counter holds afterwards, which must show that the write took priority over the step.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    typedef enum logic [1:0] {
        MD_FREE   = 2'd0,
        MD_CLEAR  = 2'd1,
        MD_UPDOWN = 2'd2,
        MD_FREQ   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        CS_OFF      = 2'd0,
        CS_TICK     = 2'd1,
        CS_EVT_RISE = 2'd2,
        CS_EVT_FALL = 2'd3
    } csel_e;

    typedef struct packed {
        logic  sleep;
        logic  filt;
        logic  cap_rise;
        csel_e csel;
        mode_e mode;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmr16_sync.sv
module tmr16_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/tmr16_capfilt.sv
module tmr16_capfilt #(
    parameter int unsigned FILT_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic filt_en,
    input  logic rise_sel,
    output logic edge_o
);
    typedef struct packed {
        logic [FILT_N-1:0] hist;
        logic              lvl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.hist = {st_q.hist[FILT_N-2:0], din};
        if (!filt_en)          st_d.lvl = din;
        else if (&st_q.hist)   st_d.lvl = 1'b1;
        else if (~|st_q.hist)  st_d.lvl = 1'b0;
        edge_o = rise_sel ? (st_d.lvl & ~st_q.lvl) : (~st_d.lvl & st_q.lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr16_engine.sv
module tmr16_engine
    import tmr16_pkg::*;
#(
    parameter int unsigned W   = 16,
    parameter int unsigned NCH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  mode_e                   mode,
    input  logic                    step_i,
    input  logic                    load_i,
    input  logic [W-1:0]            lim_i,
    input  logic [NCH-1:0][W-1:0]   buf_i,
    input  logic                    cnt_we,
    input  logic [W-1:0]            cnt_wd,
    output logic [W-1:0]            cnt_o,
    output logic [NCH-1:0]          wave_o,
    output logic [NCH-1:0]          match_o,
    output logic                    ovf_o
);
    typedef struct packed {
        logic [W-1:0]          cnt;
        logic                  dn;
        logic [NCH-1:0][W-1:0] act;
        logic [NCH-1:0]        wave;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] nxt, lim;
    logic         dn_n, upd, wrap, go;

    always_comb begin
        st_d    = st_q;
        go      = step_i & ~cnt_we;
        lim     = (mode == MD_FREQ) ? st_q.act[0] : lim_i;
        nxt     = st_q.cnt + 1'b1;
        dn_n    = st_q.dn;
        upd     = 1'b0;
        wrap    = 1'b0;
        match_o = '0;
        case (mode)
            MD_FREE: begin
                if (st_q.cnt == '1) begin
                    wrap = 1'b1;
                    upd  = 1'b1;
                end
            end
            MD_CLEAR, MD_FREQ: begin
                if (st_q.cnt == lim) begin
                    nxt  = '0;
                    wrap = 1'b1;
                    upd  = 1'b1;
                end
            end
            default: begin
                if (lim == '0) begin
                    nxt = '0;
                end else if (!st_q.dn) begin
                    if (nxt >= lim) begin
                        dn_n = 1'b1;
                        upd  = 1'b1;
                    end
                end else begin
                    nxt = st_q.cnt - 1'b1;
                    if (nxt == '0) begin
                        dn_n = 1'b0;
                        wrap = 1'b1;
                    end
                end
            end
        endcase
        if (go) begin
            st_d.cnt = nxt;
            st_d.dn  = dn_n;
            for (int i = 0; i < NCH; i++) begin
                match_o[i] = (nxt == st_q.act[i]);
            end
            st_d.wave = st_q.wave ^ match_o;
            if (upd) st_d.act = buf_i;
        end
        ovf_o = go & wrap;
        if (load_i) st_d.act = buf_i;
        if (cnt_we) begin
            st_d.cnt = cnt_wd;
            st_d.dn  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign wave_o = st_q.wave;
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int unsigned W      = 16,
    parameter int unsigned NCH    = 3,
    parameter int unsigned AW     = 4,
    parameter int unsigned FILT_N = 4,
    parameter int unsigned SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    input  logic              tick_i,
    input  logic              evt_i,
    input  logic              cap_i,
    output logic [NCH-1:0]    wave_o,
    output logic [NCH+1:0]    irq_o
);
    localparam int unsigned NF = NCH + 2;
    localparam logic [AW-1:0] AD_CTRL  = AW'(0);
    localparam logic [AW-1:0] AD_COUNT = AW'(1);
    localparam logic [AW-1:0] AD_LIM   = AW'(2);
    localparam logic [AW-1:0] AD_CMP0  = AW'(3);
    localparam logic [AW-1:0] AD_CAPT  = AW'(3 + NCH);
    localparam logic [AW-1:0] AD_FLAGS = AW'(4 + NCH);
    localparam logic [AW-1:0] AD_IEN   = AW'(5 + NCH);

    typedef struct packed {
        ctrl_t                 ctrl;
        logic [W-1:0]          lim;
        logic [NCH-1:0][W-1:0] cbuf;
        logic [W-1:0]          capt;
        logic [NF-1:0]         flags;
        logic [NF-1:0]         ien;
        logic                  evt_prev;
    } regs_t;

    regs_t          rg_d, rg_q;
    logic           evt_s, cap_s, cap_edge, step, cnt_we, flag_wr, ovf_ev;
    logic [W-1:0]   cnt;
    logic [NCH-1:0] match_ev;
    logic [NF-1:0]  clr_m, set_m;
    mode_e          mode_w;
    logic           sleep_w;

    tmr16_sync #(.STAGES(SYNC_N)) u_evt_sync (
        .clk(clk), .rst_n(rst_n), .din(evt_i), .dout(evt_s));
    tmr16_sync #(.STAGES(SYNC_N)) u_cap_sync (
        .clk(clk), .rst_n(rst_n), .din(cap_i), .dout(cap_s));

    tmr16_capfilt #(.FILT_N(FILT_N)) u_filt (
        .clk(clk), .rst_n(rst_n), .din(cap_s),
        .filt_en(rg_q.ctrl.filt), .rise_sel(rg_q.ctrl.cap_rise),
        .edge_o(cap_edge));

    tmr16_engine #(.W(W), .NCH(NCH)) u_eng (
        .clk(clk), .rst_n(rst_n), .mode(rg_q.ctrl.mode), .step_i(step),
        .load_i(rg_q.ctrl.csel == CS_OFF), .lim_i(rg_q.lim), .buf_i(rg_q.cbuf),
        .cnt_we(cnt_we), .cnt_wd(wdata), .cnt_o(cnt), .wave_o(wave_o),
        .match_o(match_ev), .ovf_o(ovf_ev));

    always_comb begin
        rg_d          = rg_q;
        rg_d.evt_prev = evt_s;
        mode_w        = rg_q.ctrl.mode;
        sleep_w       = rg_q.ctrl.sleep;
        case (rg_q.ctrl.csel)
            CS_TICK:     step = tick_i;
            CS_EVT_RISE: step = evt_s & ~rg_q.evt_prev;
            CS_EVT_FALL: step = ~evt_s & rg_q.evt_prev;
            default:     step = 1'b0;
        endcase
        step    = step & ~rg_q.ctrl.sleep;
        cnt_we  = wr_en && (addr == AD_COUNT);
        flag_wr = wr_en && (addr == AD_FLAGS);
        clr_m   = flag_wr ? wdata[NF-1:0] : '0;
        set_m   = {cap_edge & ~rg_q.ctrl.sleep, match_ev, ovf_ev};
        if (set_m[NF-1]) rg_d.capt = cnt;
        rg_d.flags = (rg_q.flags & ~clr_m) | set_m;
        if (wr_en) begin
            if (addr == AD_CTRL) rg_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
            if (addr == AD_LIM)  rg_d.lim  = wdata;
            if (addr == AD_IEN)  rg_d.ien  = wdata[NF-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (addr == AD_CMP0 + AW'(i)) rg_d.cbuf[i] = wdata;
            end
        end
        rdata = '0;
        if (addr == AD_CTRL)  rdata[CTRL_W-1:0] = rg_q.ctrl;
        if (addr == AD_COUNT) rdata = cnt;
        if (addr == AD_LIM)   rdata = rg_q.lim;
        if (addr == AD_CAPT)  rdata = rg_q.capt;
        if (addr == AD_FLAGS) rdata[NF-1:0] = rg_q.flags;
        if (addr == AD_IEN)   rdata[NF-1:0] = rg_q.ien;
        for (int i = 0; i < NCH; i++) begin
            if (addr == AD_CMP0 + AW'(i)) rdata = rg_q.cbuf[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign irq_o = rg_q.flags & rg_q.ien;
endmodule

// File: rtl/tmr16_core_chk.sv
module tmr16_core_chk
    import tmr16_pkg::*;
#(
    parameter int unsigned W   = 16,
    parameter int unsigned NCH = 3,
    parameter int unsigned NF  = 5
) (
    input logic           clk,
    input logic           rst_n,
    input mode_e          mode,
    input logic           sleep,
    input logic           step,
    input logic           cnt_we,
    input logic           flag_wr,
    input logic [W-1:0]   cnt,
    input logic [W-1:0]   lim,
    input logic [NF-1:0]  flags,
    input logic [NCH-1:0] wave
);
    assert_free_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_FREE && step && !cnt_we) |=> cnt == W'($past(cnt) + 1'b1));

    assert_clear_at_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_CLEAR && step && !cnt_we && cnt == lim) |=> cnt == '0);

    assert_wave_needs_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step) |=> $stable(wave));

    assert_flags_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_wr) |=> ((flags & $past(flags)) == $past(flags)));

    assert_sleep_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !cnt_we) |=> $stable(cnt));
endmodule

bind tmr16_core tmr16_core_chk #(.W(W), .NCH(NCH), .NF(NCH + 2)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode_w), .sleep(sleep_w), .step(step),
    .cnt_we(cnt_we), .flag_wr(flag_wr), .cnt(cnt), .lim(rg_q.lim),
    .flags(rg_q.flags), .wave(wave_o));

// File: tb/tmr16_core_test.sv
module tmr16_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        tick_i = 1'b0;
    logic        evt_i = 1'b0;
    logic        cap_i = 1'b0;
    logic [2:0]  wave_o;
    logic [4:0]  irq_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    localparam logic [3:0] RA_CTRL = 4'd0, RA_CNT = 4'd1, RA_LIM = 4'd2,
                           RA_CA = 4'd3, RA_CB = 4'd4, RA_CC = 4'd5,
                           RA_CAP = 4'd6, RA_FLG = 4'd7, RA_IEN = 4'd8;

    typedef struct packed {
        logic [1:0]  md;
        logic [15:0] start;
        logic [15:0] lim;
        logic [15:0] cmpa;
        logic [7:0]  steps;
        logic [15:0] exp_cnt;
        logic [1:0]  exp_flg;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 16'd0,     16'd0, 16'd3,   8'd5, 16'd5,   2'b10},
        '{2'd0, 16'hFFFE,  16'd0, 16'd0,   8'd3, 16'd1,   2'b11},
        '{2'd1, 16'd0,     16'd4, 16'd2,   8'd7, 16'd2,   2'b11},
        '{2'd1, 16'd0,     16'd4, 16'd9,   8'd4, 16'd4,   2'b00},
        '{2'd2, 16'd0,     16'd3, 16'd2,   8'd5, 16'd1,   2'b10},
        '{2'd2, 16'd0,     16'd3, 16'd5,   8'd7, 16'd1,   2'b01},
        '{2'd3, 16'd0,     16'd0, 16'd2,   8'd5, 16'd2,   2'b11},
        '{2'd0, 16'd100,   16'd0, 16'd100, 8'd0, 16'd100, 2'b00}
    };

    tmr16_core uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick_i(tick_i), .evt_i(evt_i), .cap_i(cap_i),
        .wave_o(wave_o), .irq_o(irq_o));

    always #2.5 clk = ~clk;

    function automatic logic [15:0] cv(input logic [1:0] md, input logic [1:0] cs,
                                       input logic rise, input logic filt,
                                       input logic slp);
        return {9'd0, slp, filt, rise, cs, md};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick_i = 1'b1;
            @(negedge clk) tick_i = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, c0, c1, w0;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        rd(RA_CNT, v);  chk("R1 count", v, 16'd0);
        rd(RA_FLG, v);  chk("R1 flags", v, 16'd0);
        chk("R1 irq/wave", {8'd0, irq_o, wave_o}, 16'd0);

        // R2..R6, R13 table walk
        for (int i = 0; i < 8; i++) begin
            string tg;
            case (VECS[i].md)
                2'd0: tg = "R2 count";
                2'd1: tg = "R3 count";
                2'd2: tg = "R4 count";
                default: tg = "R5 count";
            endcase
            wr(RA_CTRL, cv(VECS[i].md, 2'd0, 1'b1, 1'b0, 1'b0));
            wr(RA_LIM, VECS[i].lim);
            wr(RA_CA, VECS[i].cmpa);
            wr(RA_CB, 16'hFFFF);
            wr(RA_CC, 16'hFFFF);
            wr(RA_CNT, VECS[i].start);
            wr(RA_FLG, 16'h001F);
            wr(RA_CTRL, cv(VECS[i].md, 2'd1, 1'b1, 1'b0, 1'b0));
            ticks(int'(VECS[i].steps));
            wr(RA_CTRL, cv(VECS[i].md, 2'd0, 1'b1, 1'b0, 1'b0));
            rd(RA_CNT, v); chk(tg, v, VECS[i].exp_cnt);
            rd(RA_FLG, v); chk("R6 flags", {14'd0, v[1:0]}, {14'd0, VECS[i].exp_flg});
        end

        // R4 waveform toggles on the way up and on the way down
        wr(RA_LIM, 16'd3); wr(RA_CA, 16'd2); wr(RA_CNT, 16'd0);
        wr(RA_CTRL, cv(2'd2, 2'd1, 1'b1, 1'b0, 1'b0));
        w0 = {15'd0, wave_o[0]};
        ticks(2);
        chk("R4 wave up", {15'd0, wave_o[0]}, w0 ^ 16'd1);
        ticks(2);
        chk("R4 wave down", {15'd0, wave_o[0]}, w0);

        // R7 double buffering in mode 1
        wr(RA_CTRL, cv(2'd1, 2'd0, 1'b1, 1'b0, 1'b0));
        wr(RA_LIM, 16'd9); wr(RA_CA, 16'd5); wr(RA_CNT, 16'd0); wr(RA_FLG, 16'h1F);
        wr(RA_CTRL, cv(2'd1, 2'd1, 1'b1, 1'b0, 1'b0));
        ticks(2);
        wr(RA_CA, 16'd7);
        ticks(3);
        rd(RA_FLG, v); chk("R7 old value matches", {15'd0, v[1]}, 16'd1);
        wr(RA_FLG, 16'h1F);
        ticks(2);
        rd(RA_FLG, v); chk("R7 new value not yet active", {15'd0, v[1]}, 16'd0);
        ticks(10);
        rd(RA_FLG, v); chk("R7 new value after wrap", {15'd0, v[1]}, 16'd1);

        // R8 external event clock, rising edges
        wr(RA_CTRL, cv(2'd0, 2'd2, 1'b1, 1'b0, 1'b0));
        wr(RA_CNT, 16'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk) evt_i = 1'b1; idle(4);
            @(negedge clk) evt_i = 1'b0; idle(4);
        end
        rd(RA_CNT, v); chk("R8 rising events", v, 16'd3);
        wr(RA_CTRL, cv(2'd0, 2'd3, 1'b1, 1'b0, 1'b0));
        wr(RA_CNT, 16'd0);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk) evt_i = 1'b1; idle(4);
            @(negedge clk) evt_i = 1'b0; idle(4);
        end
        rd(RA_CNT, v); chk("R8 falling events", v, 16'd2);

        // R12 sleep freezes counting and capture
        wr(RA_CTRL, cv(2'd0, 2'd1, 1'b1, 1'b0, 1'b1));
        wr(RA_CNT, 16'd50); wr(RA_FLG, 16'h1F);
        ticks(5);
        @(negedge clk) cap_i = 1'b1; idle(10);
        rd(RA_CNT, v); chk("R12 count frozen", v, 16'd50);
        rd(RA_FLG, v); chk("R12 no capture", {15'd0, v[4]}, 16'd0);
        @(negedge clk) cap_i = 1'b0; idle(10);

        // R9 capture on rising and falling edge
        wr(RA_CTRL, cv(2'd0, 2'd0, 1'b1, 1'b0, 1'b0));
        wr(RA_CNT, 16'h1234); wr(RA_FLG, 16'h1F);
        @(negedge clk) cap_i = 1'b1; idle(8);
        rd(RA_CAP, v); chk("R9 rising capture", v, 16'h1234);
        rd(RA_FLG, v); chk("R9 capture flag", {15'd0, v[4]}, 16'd1);
        wr(RA_CTRL, cv(2'd0, 2'd0, 1'b0, 1'b0, 1'b0));
        wr(RA_CNT, 16'h0ABC);
        @(negedge clk) cap_i = 1'b0; idle(8);
        rd(RA_CAP, v); chk("R9 falling capture", v, 16'h0ABC);

        // R10 filter rejects a three-clock pulse
        wr(RA_CTRL, cv(2'd0, 2'd0, 1'b1, 1'b1, 1'b0));
        idle(10);
        wr(RA_FLG, 16'h1F);
        @(negedge clk) cap_i = 1'b1; idle(2);
        @(negedge clk) cap_i = 1'b0; idle(10);
        rd(RA_FLG, v); chk("R10 short pulse ignored", {15'd0, v[4]}, 16'd0);

        // R10 filter latency of four clocks
        for (int f = 0; f < 2; f++) begin
            wr(RA_CTRL, cv(2'd0, 2'd1, 1'b1, f[0], 1'b0));
            @(negedge clk) tick_i = 1'b1;
            idle(10);
            wr(RA_CNT, 16'd0);
            idle(3);
            @(negedge clk) cap_i = 1'b1; idle(15);
            @(negedge clk) cap_i = 1'b0; idle(15);
            tick_i = 1'b0;
            rd(RA_CAP, v);
            if (f == 0) c0 = v; else c1 = v;
        end
        chk("R10 filter delay", c1, c0 + 16'd4);

        // R11 set wins over clear in the same cycle; R6 counter write beats step
        wr(RA_CTRL, cv(2'd0, 2'd0, 1'b1, 1'b0, 1'b0));
        wr(RA_CA, 16'd10);
        wr(RA_CTRL, cv(2'd0, 2'd1, 1'b1, 1'b0, 1'b0));
        wr(RA_FLG, 16'h1F);
        @(negedge clk);
        tick_i = 1'b1; wr_en = 1'b1; addr = RA_CNT; wdata = 16'd9;
        @(negedge clk);
        addr = RA_FLG; wdata = 16'h0002;
        @(negedge clk);
        wr_en = 1'b0; tick_i = 1'b0;
        rd(RA_CNT, v); chk("R6 write beats step", v, 16'd10);
        rd(RA_FLG, v); chk("R11 set wins over clear", {15'd0, v[1]}, 16'd1);
        wr(RA_IEN, 16'h0002);
        #1 chk("R11 irq enabled", {11'd0, irq_o}, 16'h0002);
        wr(RA_IEN, 16'h0000);
        #1 chk("R11 irq masked", {11'd0, irq_o}, 16'h0000);
        wr(RA_FLG, 16'h0002);
        rd(RA_FLG, v); chk("R11 write one clears", {15'd0, v[1]}, 16'd0);
        rd(RA_CA, v); chk("R13 compare A address", v, 16'd10);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule